// File: doc/BRIEF.md
# Triggered Burst Parallel-to-Serial Shifter

This block turns a parallel word into a serial bit stream in bursts of a fixed length. While it waits, it copies the parallel input into its internal register on every clock. When the trigger input is sampled high in that waiting phase, the word present at that edge becomes the burst word. The block then moves it out most significant bit first, one bit per clock, for exactly `SHIFTS` clocks. Zeros enter at the least significant end.

During the burst the trigger input and the parallel input are both ignored. When the last shift completes, the controller goes back to waiting on its own, without any reset. An asynchronous active-low reset forces the waiting phase and clears the register. The register is not loaded from the data input inside the reset branch, so the upstream source does not have to present data while reset is held. A busy flag marks the burst.

Top module: `burst_p2s`

## Requirements
- R1: While `rst_ni` is low, `busy_o` is 0 and `ser_o` is 0.
- R2: While the block is waiting, each clock edge copies `par_i` into the register, so `ser_o` equals bit `WIDTH-1` of `par_i` as sampled at the previous edge.
- R3: A clock edge that samples `trig_i` high while waiting raises `busy_o`. `busy_o` then stays high for exactly `SHIFTS` clock cycles and falls after that.
- R4: In busy cycle j (j = 0 for the first cycle after the trigger edge), `ser_o` equals bit `WIDTH-1-j` of the `par_i` word sampled at the trigger edge. The block performs exactly one shift per clock.
- R5: The level of `trig_i` during a burst has no effect: held high, dropped low or toggled, the burst length and the bit sequence are unchanged.
- R6: Changes of `par_i` during a burst do not alter the bits shifted out.
- R7: In the first cycle after `busy_o` falls, `ser_o` shows the register after `SHIFTS` zero-filled shifts. This is bit `WIDTH-1-SHIFTS` of the burst word when `SHIFTS < WIDTH`, and 0 when `SHIFTS == WIDTH`.
- R8: The block returns to waiting without a reset. If `trig_i` is held high continuously, bursts of `SHIFTS` cycles repeat, separated by exactly one waiting cycle, and each burst carries the `par_i` word sampled at its own start edge.
- R9: Pulling `rst_ni` low in the middle of a burst clears `busy_o` and `ser_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Starts a burst when sampled high while waiting |
| par_i | input | WIDTH | Parallel word, captured every clock while waiting |
| ser_o | output | 1 | Serial data, most significant bit of the internal register |
| busy_o | output | 1 | High for the whole burst |

## Verification
Bursts are started with the trigger held high, dropped after one cycle and toggled every cycle. Matching length and bit order across the three shows that the trigger level after start is ignored. Because the parallel input is inverted during each burst, a design that kept loading while shifting would emit wrong bits. Alternating most significant bits while waiting exercise the continuous capture, a held trigger separates a restart that needs a single waiting cycle from one that needs none or two, and a reset pulled mid-burst between clock edges shows that the clear is asynchronous.

// File: rtl/burst_p2s_pkg.sv
package burst_p2s_pkg;

    typedef enum logic [0:0] {
        PH_WAIT  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

endpackage

// File: rtl/burst_p2s_ctrl.sv
module burst_p2s_ctrl
    import burst_p2s_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    input  logic last_i,
    output logic start_o,
    output logic shift_o,
    output logic wait_o
);

    typedef struct packed {
        phase_e phase;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d    = st_q;
        start_o = 1'b0;
        unique case (st_q.phase)
            PH_WAIT: begin
                if (trig_i) begin
                    start_o     = 1'b1;
                    st_d.phase  = PH_SHIFT;
                end
            end
            PH_SHIFT: begin
                // trigger level is not looked at here
                if (last_i) begin
                    st_d.phase = PH_WAIT;
                end
            end
            default: st_d.phase = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_WAIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_o = (st_q.phase == PH_SHIFT);
    assign wait_o  = (st_q.phase == PH_WAIT);

endmodule

// File: rtl/burst_p2s_cnt.sv
module burst_p2s_cnt #(
    parameter int SHIFTS = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic dec_i,
    output logic last_o
);

    generate
        if (SHIFTS == 1) begin : g_single
            // one shift per burst: every shift is the last one
            assign last_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(SHIFTS);
            localparam logic [CW-1:0] LOAD_VAL = CW'(SHIFTS - 1);

            typedef struct packed {
                logic [CW-1:0] left;
            } cnt_s;

            cnt_s c_d, c_q;

            always_comb begin
                c_d = c_q;
                if (load_i) begin
                    c_d.left = LOAD_VAL;
                end else if (dec_i && (c_q.left != '0)) begin
                    c_d.left = c_q.left - 1'b1;
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    c_q.left <= '0;
                end else begin
                    c_q <= c_d;
                end
            end

            assign last_o = (c_q.left == '0);
        end
    endgenerate

endmodule

// File: rtl/burst_p2s_dp.sv
module burst_p2s_dp #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cap_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             msb_o
);

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } dp_s;

    dp_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cap_i) begin
            r_d.word = par_i;
        end else if (shift_i) begin
            r_d.word = r_q.word << 1;
        end
    end

    // reset clears only; loading happens in the waiting phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.word <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign msb_o = r_q.word[WIDTH-1];

endmodule

// File: rtl/burst_p2s.sv
module burst_p2s #(
    parameter int WIDTH  = 8,
    parameter int SHIFTS = WIDTH
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             trig_i,
    input  logic [WIDTH-1:0] par_i,
    output logic             ser_o,
    output logic             busy_o
);

    generate
        if (SHIFTS < 1 || SHIFTS > WIDTH) begin : g_bad_cfg
            $error("burst_p2s: SHIFTS must lie in 1..WIDTH");
        end
    endgenerate

    logic start_w;
    logic shift_w;
    logic wait_w;
    logic last_w;

    burst_p2s_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (trig_i),
        .last_i  (last_w),
        .start_o (start_w),
        .shift_o (shift_w),
        .wait_o  (wait_w)
    );

    burst_p2s_cnt #(.SHIFTS(SHIFTS)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (start_w),
        .dec_i  (shift_w),
        .last_o (last_w)
    );

    burst_p2s_dp #(.WIDTH(WIDTH)) u_dp (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cap_i   (wait_w),
        .shift_i (shift_w),
        .par_i   (par_i),
        .msb_o   (ser_o)
    );

    assign busy_o = shift_w;

endmodule

// File: rtl/burst_p2s_chk.sv
module burst_p2s_chk #(
    parameter int WIDTH  = 8,
    parameter int SHIFTS = WIDTH
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             trig_i,
    input logic [WIDTH-1:0] par_i,
    input logic             ser_o,
    input logic             busy_o
);

    localparam int BW = $clog2(SHIFTS + 1) + 1;
    localparam logic [BW-1:0] LAST_IDX = BW'(SHIFTS - 1);

    logic [BW-1:0]    blen_q;
    logic [WIDTH-1:0] shadow_q;
    logic             vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            blen_q   <= '0;
            shadow_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q    <= 1'b1;
            blen_q   <= busy_o ? blen_q + 1'b1 : '0;
            shadow_q <= busy_o ? (shadow_q << 1) : par_i;
        end
    end

    assert_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && trig_i) |=> busy_o);

    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && blen_q < LAST_IDX) |=> busy_o);

    assert_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && blen_q == LAST_IDX) |=> !busy_o);

    assert_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (ser_o == shadow_q[WIDTH-1]));

    assert_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && !$past(busy_o)) |-> (ser_o == $past(par_i[WIDTH-1])));

    assert_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && $past(busy_o) && !busy_o) |-> (ser_o == shadow_q[WIDTH-1]));

    assert_nolen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && $fell(busy_o) && trig_i) |=> busy_o);

endmodule

bind burst_p2s burst_p2s_chk #(.WIDTH(WIDTH), .SHIFTS(SHIFTS)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig_i),
    .par_i  (par_i),
    .ser_o  (ser_o),
    .busy_o (busy_o)
);

// File: tb/burst_p2s_tb_top.sv
module burst_p2s_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig = 1'b0;
    logic [W-1:0] par = '0;
    logic         ser;
    logic         busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_p2s #(.WIDTH(W), .SHIFTS(N)) dut_i (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .trig_i (trig),
        .par_i  (par),
        .ser_o  (ser),
        .busy_o (busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic fill_bit(input logic [W-1:0] w);
        return (N < W) ? w[W-1-N] : 1'b0;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        par   = '1;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 ser in reset", ser, 0);
        rst_n = 1'b1;
        par   = '0;
        @(negedge clk);
    endtask

    task automatic t_idle_follow();
        logic [W-1:0] prev;
        prev = 8'h80;
        par  = prev;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            chk("R2 idle capture", ser, prev[W-1]);
            prev = (i % 2 == 0) ? 8'h3C : 8'hC3;
            par  = prev;
            @(negedge clk);
        end
    endtask

    // mode 0: trigger held high, 1: dropped, 2: toggled
    task automatic t_burst(input logic [W-1:0] p, input int mode);
        par  = p;
        trig = 1'b1;
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            par  = ~p;
            trig = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : logic'(j % 2);
            chk("R3 busy during burst", busy, 1);
            if (mode == 0) chk("R4 bit order", ser, p[W-1-j]);
            else           chk("R5 R6 bit with trig changes", ser, p[W-1-j]);
        end
        @(negedge clk);
        trig = 1'b0;
        chk("R3 busy falls after N", busy, 0);
        chk("R7 zero fill", ser, fill_bit(p));
        @(negedge clk);
        chk("R8 stays waiting", busy, 0);
        @(negedge clk);
    endtask

    task automatic t_back_to_back(input logic [W-1:0] p1, input logic [W-1:0] p2);
        par  = p1;
        trig = 1'b1;
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            par = ~p1;
            chk("R8 first burst bit", ser, p1[W-1-j]);
        end
        @(negedge clk);
        chk("R8 one idle gap", busy, 0);
        par = p2;
        for (int j = 0; j < N; j++) begin
            @(negedge clk);
            par = ~p2;
            chk("R8 restart busy", busy, 1);
            chk("R8 second burst bit", ser, p2[W-1-j]);
        end
        trig = 1'b0;
        @(negedge clk);
        chk("R8 ends after second burst", busy, 0);
        @(negedge clk);
    endtask

    task automatic t_async_reset();
        par  = 8'hFF;
        trig = 1'b1;
        repeat (3) @(negedge clk);
        trig = 1'b0;
        chk("R9 busy before reset", busy, 1);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        chk("R9 busy cleared async", busy, 0);
        chk("R9 ser cleared async", ser, 0);
        @(negedge clk);
        rst_n = 1'b1;
        par   = 8'h00;
        @(negedge clk);
        chk("R9 waiting after reset", busy, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_idle_follow();
        t_burst(8'hA5, 0);
        t_burst(8'h96, 1);
        t_burst(8'h5B, 2);
        t_burst(8'hFF, 1);
        t_back_to_back(8'hC1, 8'h3E);
        t_async_reset();
        t_burst(8'h81, 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule